// File: doc/BRIEF.md
# LED Channel Fault-Check Readback Sequencer

This block drives the diagnostic side of a 24-channel constant-current LED driver. There are eight channels for each of the red, green and blue colors. A command is sent as a run of serial clock ticks while the latch-enable line is held high. When the line drops, the run length selects one of three actions. The first action arms an open check, a short check or a combined check. The second reads back the thermal alert. The third is any other command, which belongs to other logic and leaves this block untouched.

Once a check is armed, the three active-low color output enables open the check window. A cycle counter measures the window against a minimum length in system clocks, derived from the clock frequency. The first serial tick given inside the window captures a 24-bit good/fail word from per-channel comparator flags. Later ticks shift that word out MSB first on the serial result line.

The per-color short-detection threshold choice is forwarded as a registered output to the analog comparators.

Top module: `ledd_diag_seq`

## Requirements
- R1: Tick runs of 11, 12 and 13 while latch-enable is high arm open-only, short-only and combined checks respectively. Run lengths other than 11 to 14 arm nothing and leave the result register as it was.
- R2: In open-only mode a channel fails if its open flag is set. Short flags have no effect in this mode.
- R3: In short-only mode a channel fails if its short flag is set. Open flags have no effect in this mode.
- R4: In combined mode a channel fails if either of its flags is set.
- R5: A channel whose `chan_on` bit is 0 reads 0, meaning fail, whatever its flags are.
- R6: A capture is valid only if all three enables were low for at least WIN_CYC = (CLK_HZ/1e6)*WIN_US system cycles before the capturing tick. Otherwise the captured word is all zeros.
- R7: While a check is armed, ticks given when any enable is high neither capture nor shift. The check stays armed until a tick arrives with all enables low.
- R8: The result appears on `diag_sdo` one cycle after the capturing tick. It is ordered red channel 8 down to red channel 1, then green 8 to 1, then blue 8 to 1. Channel n of color c is input bit c*8+n-1, where red=0, green=1 and blue=2. Each later tick with latch-enable low advances one bit, and zeros follow the 24th bit.
- R9: Ticks counted while latch-enable is high never shift the result.
- R10: A run of 14 loads 24 copies of `therm_hot`, which are visible on `diag_sdo` in the cycle after latch-enable falls.
- R11: `thr_sel` equals `cfg_thr_hi` delayed by one cycle. Bit 0 is red, bit 1 is green and bit 2 is blue. A value of 1 selects the higher threshold.
- R12: After reset, `diag_sdo` and `thr_sel` are 0 and no check is armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_tick | input | 1 | One-cycle strobe per serial clock rising edge |
| latch_en | input | 1 | Latch-enable level, sampled in the system clock domain |
| oe_r_n | input | 1 | Red output enable, active low |
| oe_g_n | input | 1 | Green output enable, active low |
| oe_b_n | input | 1 | Blue output enable, active low |
| chan_on | input | 24 | Latched on/off data per channel, color-major |
| open_flag | input | 24 | Current below half target, per channel |
| short_flag | input | 24 | Output voltage above threshold, per channel |
| cfg_thr_hi | input | 3 | Per-color threshold choice from configuration |
| therm_hot | input | 1 | Die above thermal alert level |
| thr_sel | output | 3 | Registered threshold choice to the comparators |
| diag_sdo | output | 1 | Serial result output |

## Verification
The two events that can share a cycle are the window counter reaching its required length and the tick that captures the result. The bench places the capture tick after exactly WIN_CYC-1 and exactly WIN_CYC cycles of all-low enables. With every channel on and no flags set, the first case must read out an all-zero word and the second an all-ones word. A second pairing is a tick arriving while a check is armed but only some enables are low. The bench judges this case by whether the register keeps its previous contents and then still captures correctly once the window opens.

// File: rtl/ledd_pkg.sv
package ledd_pkg;
  typedef enum logic [1:0] {
    CHK_OPEN  = 2'd0,
    CHK_SHORT = 2'd1,
    CHK_BOTH  = 2'd2
  } chk_mode_t;

  localparam int KEY_W     = 5;
  localparam int KEY_OPEN  = 11;
  localparam int KEY_SHORT = 12;
  localparam int KEY_BOTH  = 13;
  localparam int KEY_THERM = 14;
endpackage

// File: rtl/ledd_key_decoder.sv
module ledd_key_decoder #(
  parameter int KW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          le,
  output logic          key_valid,
  output logic [KW-1:0] key_len
);
  localparam logic [KW-1:0] CNT_MAX = '1;

  logic          le_q;
  logic [KW-1:0] cnt;

  assign key_valid = le_q & ~le;
  assign key_len   = cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      le_q <= 1'b0;
      cnt  <= '0;
    end else begin
      le_q <= le;
      if (key_valid)
        cnt <= '0;
      else if (tick && le && cnt != CNT_MAX)
        cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/ledd_window_timer.sv
module ledd_window_timer #(
  parameter int WIN = 200
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic win_ok
);
  localparam int CW = $clog2(WIN + 1);
  localparam logic [CW-1:0] LIMIT = CW'(WIN);

  logic [CW-1:0] cnt;

  assign win_ok = (cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || !run)
      cnt <= '0;
    else if (cnt != LIMIT)
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/ledd_result_former.sv
module ledd_result_former
  import ledd_pkg::*;
#(
  parameter int NCH = 8
) (
  input  chk_mode_t          mode,
  input  logic               win_ok,
  input  logic [3*NCH-1:0]   chan_on,
  input  logic [3*NCH-1:0]   open_flag,
  input  logic [3*NCH-1:0]   short_flag,
  output logic [3*NCH-1:0]   word
);
  for (genvar c = 0; c < 3; c++) begin : g_color
    for (genvar k = 0; k < NCH; k++) begin : g_chan
      localparam int SRC = c*NCH + k;
      localparam int DST = (2-c)*NCH + k;
      logic fault;
      always_comb begin
        case (mode)
          CHK_OPEN:  fault = open_flag[SRC];
          CHK_SHORT: fault = short_flag[SRC];
          default:   fault = open_flag[SRC] | short_flag[SRC];
        endcase
      end
      assign word[DST] = win_ok & chan_on[SRC] & ~fault;
    end
  end
endmodule

// File: rtl/ledd_diag_seq.sv
module ledd_diag_seq
  import ledd_pkg::*;
#(
  parameter int CLK_HZ       = 200_000_000,
  parameter int WIN_US       = 1,
  parameter int CH_PER_COLOR = 8
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      ser_tick,
  input  logic                      latch_en,
  input  logic                      oe_r_n,
  input  logic                      oe_g_n,
  input  logic                      oe_b_n,
  input  logic [3*CH_PER_COLOR-1:0] chan_on,
  input  logic [3*CH_PER_COLOR-1:0] open_flag,
  input  logic [3*CH_PER_COLOR-1:0] short_flag,
  input  logic [2:0]                cfg_thr_hi,
  input  logic                      therm_hot,
  output logic [2:0]                thr_sel,
  output logic                      diag_sdo
);
  localparam int W       = 3 * CH_PER_COLOR;
  localparam int WIN_RAW = (CLK_HZ / 1_000_000) * WIN_US;
  localparam int WIN_CYC = (WIN_RAW < 1) ? 1 : WIN_RAW;

  logic             key_valid;
  logic [KEY_W-1:0] key_len;
  logic             win_ok;
  logic             armed;
  chk_mode_t        mode;
  logic [W-1:0]     shreg;
  logic [W-1:0]     word;
  logic             all_low;
  logic             cap;
  logic             shift;

  assign all_low = ~(oe_r_n | oe_g_n | oe_b_n);
  assign cap     = armed & ser_tick & ~latch_en & all_low;
  assign shift   = ~armed & ser_tick & ~latch_en;

  ledd_key_decoder #(.KW(KEY_W)) u_key (
    .clk       (clk),
    .rst       (rst),
    .tick      (ser_tick),
    .le        (latch_en),
    .key_valid (key_valid),
    .key_len   (key_len)
  );

  ledd_window_timer #(.WIN(WIN_CYC)) u_win (
    .clk    (clk),
    .rst    (rst),
    .run    (armed & all_low),
    .win_ok (win_ok)
  );

  ledd_result_former #(.NCH(CH_PER_COLOR)) u_form (
    .mode       (mode),
    .win_ok     (win_ok),
    .chan_on    (chan_on),
    .open_flag  (open_flag),
    .short_flag (short_flag),
    .word       (word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      armed   <= 1'b0;
      mode    <= CHK_OPEN;
      shreg   <= '0;
      thr_sel <= '0;
    end else begin
      thr_sel <= cfg_thr_hi;
      if (key_valid) begin
        if (key_len == KEY_W'(KEY_OPEN)) begin
          armed <= 1'b1;
          mode  <= CHK_OPEN;
        end else if (key_len == KEY_W'(KEY_SHORT)) begin
          armed <= 1'b1;
          mode  <= CHK_SHORT;
        end else if (key_len == KEY_W'(KEY_BOTH)) begin
          armed <= 1'b1;
          mode  <= CHK_BOTH;
        end else if (key_len == KEY_W'(KEY_THERM)) begin
          armed <= 1'b0;
          shreg <= {W{therm_hot}};
        end
      end else if (cap) begin
        shreg <= word;
        armed <= 1'b0;
      end else if (shift) begin
        shreg <= {shreg[W-2:0], 1'b0};
      end
    end
  end

  assign diag_sdo = shreg[W-1];
endmodule

// File: rtl/ledd_diag_checker.sv
module ledd_diag_checker #(
  parameter int KW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          latch_en,
  input logic          ser_tick,
  input logic          armed,
  input logic          cap,
  input logic          win_ok,
  input logic          key_valid,
  input logic [KW-1:0] key_len,
  input logic          therm_hot,
  input logic          red_top_on,
  input logic          next_bit,
  input logic [2:0]    cfg_thr_hi,
  input logic [2:0]    thr_sel,
  input logic          diag_sdo
);
  a_r11_thr_follow: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> thr_sel == $past(cfg_thr_hi));

  a_r10_therm_load: assert property (@(posedge clk) disable iff (rst)
    (key_valid && key_len == KW'(14)) |=> diag_sdo == $past(therm_hot));

  a_r9_le_hold: assert property (@(posedge clk) disable iff (rst)
    latch_en |=> $stable(diag_sdo));

  a_r6_short_window: assert property (@(posedge clk) disable iff (rst)
    (cap && !win_ok) |=> !diag_sdo);

  a_r5_off_channel: assert property (@(posedge clk) disable iff (rst)
    (cap && !red_top_on) |=> !diag_sdo);

  a_r8_shift_step: assert property (@(posedge clk) disable iff (rst)
    (ser_tick && !latch_en && !armed && !key_valid) |=> diag_sdo == $past(next_bit));
endmodule

bind ledd_diag_seq ledd_diag_checker #(.KW(ledd_pkg::KEY_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .latch_en   (latch_en),
  .ser_tick   (ser_tick),
  .armed      (armed),
  .cap        (cap),
  .win_ok     (win_ok),
  .key_valid  (key_valid),
  .key_len    (key_len),
  .therm_hot  (therm_hot),
  .red_top_on (chan_on[CH_PER_COLOR-1]),
  .next_bit   (shreg[3*CH_PER_COLOR-2]),
  .cfg_thr_hi (cfg_thr_hi),
  .thr_sel    (thr_sel),
  .diag_sdo   (diag_sdo)
);

// File: tb/tb_ledd_diag_seq.sv
`timescale 1ns/1ps
module tb_ledd_diag_seq;
  localparam int WIN = 200;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ser_tick = 1'b0;
  logic latch_en = 1'b0;
  logic oe_r_n = 1'b1, oe_g_n = 1'b1, oe_b_n = 1'b1;
  logic [23:0] chan_on = '0, open_flag = '0, short_flag = '0;
  logic [2:0] cfg_thr_hi = '0;
  logic therm_hot = 1'b0;
  logic [2:0] thr_sel;
  logic diag_sdo;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ledd_diag_seq dut (
    .clk(clk), .rst(rst), .ser_tick(ser_tick), .latch_en(latch_en),
    .oe_r_n(oe_r_n), .oe_g_n(oe_g_n), .oe_b_n(oe_b_n),
    .chan_on(chan_on), .open_flag(open_flag), .short_flag(short_flag),
    .cfg_thr_hi(cfg_thr_hi), .therm_hot(therm_hot),
    .thr_sel(thr_sel), .diag_sdo(diag_sdo)
  );

  task automatic check(input logic [23:0] act, input logic [23:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick_once();
    ser_tick = 1'b1;
    @(negedge clk);
    ser_tick = 1'b0;
  endtask

  task automatic send_key(input int n);
    latch_en = 1'b1;
    for (int i = 0; i < n; i++) begin
      ser_tick = 1'b1;
      @(negedge clk);
      ser_tick = 1'b0;
      @(negedge clk);
    end
    latch_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic read_rest(inout logic [23:0] s);
    for (int p = 1; p < 24; p++) begin
      tick_once();
      s[23-p] = diag_sdo;
    end
  endtask

  task automatic run_check(input int key, input int nwait, output logic [23:0] s);
    send_key(key);
    oe_r_n = 1'b0; oe_g_n = 1'b0; oe_b_n = 1'b0;
    repeat (nwait) @(negedge clk);
    tick_once();
    s = '0;
    s[23] = diag_sdo;
    oe_r_n = 1'b1; oe_g_n = 1'b1; oe_b_n = 1'b1;
    @(negedge clk);
    read_rest(s);
  endtask

  function automatic logic [23:0] expect_word(input int mode, input logic [23:0] on,
      input logic [23:0] op, input logic [23:0] sh, input bit ok);
    logic [23:0] r;
    for (int p = 0; p < 24; p++) begin
      int c = p / 8;
      int ch = 8 - (p % 8);
      int idx = c*8 + ch - 1;
      logic f;
      f = (mode == 0) ? op[idx] : (mode == 1) ? sh[idx] : (op[idx] | sh[idx]);
      r[23-p] = ok & on[idx] & ~f;
    end
    return r;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [23:0] s;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R12 reset state
    check({23'd0, diag_sdo}, 24'd0, "R12 sdo");
    check({21'd0, thr_sel}, 24'd0, "R12 thr_sel");

    // R11 threshold forwarding
    cfg_thr_hi = 3'b101;
    @(negedge clk);
    check({21'd0, thr_sel}, 24'h5, "R11 thr_sel");
    cfg_thr_hi = 3'b010;
    @(negedge clk);
    check({21'd0, thr_sel}, 24'h2, "R11 thr_sel");

    // R2 R3 R4 R5 R8 sweep over modes and flag patterns
    for (int m = 0; m < 3; m++) begin
      for (int sd = 0; sd < 8; sd++) begin
        for (int i = 0; i < 24; i++) begin
          int cb = (i*5 + sd) % 8;
          chan_on[i] = cb[0]; open_flag[i] = cb[1]; short_flag[i] = cb[2];
        end
        run_check(11 + m, WIN, s);
        check(s, expect_word(m, chan_on, open_flag, short_flag, 1'b1),
              m == 0 ? "R2 R5 R8 open" : m == 1 ? "R3 R5 R8 short" : "R4 R5 R8 combined");
      end
    end

    // R6 window boundary
    chan_on = '1; open_flag = '0; short_flag = '0;
    run_check(13, WIN - 1, s);
    check(s, 24'h000000, "R6 short window");
    run_check(13, WIN, s);
    check(s, 24'hFFFFFF, "R6 exact window");

    // R10 thermal readback, R8 zero fill
    therm_hot = 1'b1;
    send_key(14);
    s = '0; s[23] = diag_sdo;
    read_rest(s);
    check(s, 24'hFFFFFF, "R10 hot");
    tick_once();
    check({23'd0, diag_sdo}, 24'd0, "R8 zero fill");
    therm_hot = 1'b0;
    send_key(14);
    s = '0; s[23] = diag_sdo;
    read_rest(s);
    check(s, 24'h000000, "R10 cold");

    // R7 partial enables neither capture nor shift
    therm_hot = 1'b1;
    send_key(14);
    chan_on = 24'hA5C3_5A; open_flag = '0; short_flag = '0;
    send_key(11);
    oe_r_n = 1'b0; oe_g_n = 1'b1; oe_b_n = 1'b0;
    repeat (WIN + 5) @(negedge clk);
    tick_once();
    check({23'd0, diag_sdo}, 24'd1, "R7 no capture");
    oe_g_n = 1'b0;
    repeat (WIN) @(negedge clk);
    tick_once();
    s = '0; s[23] = diag_sdo;
    oe_r_n = 1'b1; oe_g_n = 1'b1; oe_b_n = 1'b1;
    @(negedge clk);
    read_rest(s);
    check(s, expect_word(0, chan_on, open_flag, short_flag, 1'b1), "R7 still armed");

    // R1 unrecognised run lengths arm nothing
    therm_hot = 1'b1;
    send_key(14);
    chan_on = '0;
    send_key(10);
    oe_r_n = 1'b0; oe_g_n = 1'b0; oe_b_n = 1'b0;
    repeat (WIN) @(negedge clk);
    tick_once();
    check({23'd0, diag_sdo}, 24'd1, "R1 key 10");
    oe_r_n = 1'b1; oe_g_n = 1'b1; oe_b_n = 1'b1;
    send_key(15);
    oe_r_n = 1'b0; oe_g_n = 1'b0; oe_b_n = 1'b0;
    repeat (WIN) @(negedge clk);
    tick_once();
    check({23'd0, diag_sdo}, 24'd1, "R1 key 15");
    oe_r_n = 1'b1; oe_g_n = 1'b1; oe_b_n = 1'b1;

    // R9 ticks under latch-enable do not shift
    chan_on = 24'h000080; open_flag = '0; short_flag = '0;
    send_key(13);
    oe_r_n = 1'b0; oe_g_n = 1'b0; oe_b_n = 1'b0;
    repeat (WIN) @(negedge clk);
    tick_once();
    oe_r_n = 1'b1; oe_g_n = 1'b1; oe_b_n = 1'b1;
    check({23'd0, diag_sdo}, 24'd1, "R8 first bit red ch8");
    send_key(1);
    check({23'd0, diag_sdo}, 24'd1, "R9 hold under LE");
    tick_once();
    check({23'd0, diag_sdo}, 24'd0, "R9 shift after LE");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule